// File: doc/BRIEF.md
# Conditional Branch and Call Sequencer

This block computes the program counter of a DSP core with 16-bit instruction addresses. Each cycle with a valid instruction it decodes the opcode and picks the next PC: an absolute target from the word after the opcode, a target read from an address register, a return address popped from its own call stack, a skip over the following instruction, or plain sequential advance. The condition test is done outside the block and arrives as a single bit. A condition field of all ones means "always".

It owns an eight-entry LIFO of return addresses. For return-from-interrupt it also asks an external data stack to give up the saved status word, and writes that word to the status register in the same cycle. A halt instruction freezes the PC until the halt flag is cleared from outside. Stack misuse, meaning a push when full or a pop when empty, raises a sticky error flag and leaves the stack depth unchanged.

Top module: `branch_seq`

## Requirements
- R1: After reset the PC is 0x0000, `halted` is 0, `stackErr` is 0 and the call stack is empty.
- R2: Jump-absolute (opcode 0x029c, c = condition field in bits 3:0) loads the PC with `nextWord` when taken. When not taken, the PC becomes PC+2.
- R3: A condition field of 4'hF makes a conditional instruction taken whatever `condMet` is. Any other value follows `condMet`.
- R4: Call-absolute (0x02Bc) pushes PC+2 and loads `nextWord` when taken. When not taken, the PC becomes PC+2 and nothing is pushed.
- R5: Register forms (0x17xx, bit 4 = 0 jump, bit 4 = 1 call) put bits 7:5 on `regSel` and load `regData` when taken. The call form pushes PC+1. When not taken, the PC becomes PC+1.
- R6: Return (0x02Dc) pops the call stack into the PC when taken. When not taken, the PC becomes PC+1 and nothing is popped.
- R7: Return-from-interrupt (0x02FF) always pops the PC and, in the same cycle, asserts `srWrEn` and `dsPop` with `srWrData` equal to `dsTop`.
- R8: Skip-if (0x027c) moves the PC to PC+1 when taken, and to PC+1+`nextLen` when not taken.
- R9: Halt (0x0021) moves the PC to PC+1 and sets `halted` at the same edge. While `halted` is set, the PC holds and instructions are ignored. `haltClr` clears it. A halt executing in the same cycle as `haltClr` leaves `halted` set.
- R10: The call stack holds 8 entries in LIFO order. A push when full sets `stackErr`, stores nothing and still loads the target. A pop when empty sets `stackErr` and moves the PC to PC+1.
- R11: `stackErr` stays set until reset.
- R12: Any other opcode with `valid` advances the PC by 1. With `valid` low, the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 16 | Instruction word at the current PC |
| nextWord | input | 16 | Word following the opcode (absolute target) |
| regData | input | 16 | Register-file read data for the register selected by `regSel` |
| condMet | input | 1 | External condition result for the opcode's condition field |
| nextLen | input | 2 | Length in words of the instruction after the current one |
| dsTop | input | 16 | Top entry of the external data stack |
| haltClr | input | 1 | Clears the halt flag |
| regSel | output | 3 | Address-register select for register-indirect forms |
| pc | output | 16 | Current program counter |
| srWrEn | output | 1 | Status register write strobe |
| srWrData | output | 16 | Status register write value |
| dsPop | output | 1 | Pop strobe to the external data stack |
| halted | output | 1 | Halt flag |
| stackErr | output | 1 | Sticky call-stack overflow or underflow flag |

## Verification
Two things can land in the same cycle here: a halt being executed and a halt clear being requested. The bench provokes this by presenting the halt opcode with `valid` while `haltClr` is held high. It then judges at the ports that `halted` is still set and that a following taken jump leaves the PC unchanged. A second collision, a call that overflows the stack while still loading its target, is judged by checking the new PC, the error flag, and the LIFO order of the eight addresses that were kept.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;

  typedef enum logic [2:0] {
    PC_INC1,
    PC_INC2,
    PC_IMM,
    PC_REG,
    PC_POP,
    PC_SKIP,
    PC_HOLD
  } pcSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   push;
    logic   pushTwo;
    logic   pop;
    logic   setHalt;
  } strobe_t;

  localparam logic [11:0] OP_JABS  = 12'h029;
  localparam logic [11:0] OP_CABS  = 12'h02B;
  localparam logic [11:0] OP_RET   = 12'h02D;
  localparam logic [11:0] OP_SKIP  = 12'h027;
  localparam logic [7:0]  OP_RIND  = 8'h17;
  localparam logic [15:0] OP_RTI   = 16'h02FF;
  localparam logic [15:0] OP_HALT  = 16'h0021;
  localparam logic [3:0]  COND_ALL = 4'hF;

endpackage

// File: rtl/branch_seq_ctrl.sv
module branch_seq_ctrl
  import branch_seq_pkg::*;
(
  input  logic        exec,
  input  logic [15:0] opcode,
  input  logic        condMet,
  output strobe_t     st,
  output logic [2:0]  regSel,
  output logic        srWrEn,
  output logic        dsPop
);

  logic taken;
  assign taken  = (opcode[3:0] == COND_ALL) || condMet;
  assign regSel = opcode[7:5];

  always_comb begin
    st       = '{pcSel: PC_HOLD, push: 1'b0, pushTwo: 1'b0, pop: 1'b0, setHalt: 1'b0};
    srWrEn   = 1'b0;
    dsPop    = 1'b0;
    if (exec) begin
      st.pcSel = PC_INC1;
      if (opcode == OP_RTI) begin
        st.pcSel = PC_POP;
        st.pop   = 1'b1;
        srWrEn   = 1'b1;
        dsPop    = 1'b1;
      end else if (opcode == OP_HALT) begin
        st.setHalt = 1'b1;
      end else if (opcode[15:4] == OP_JABS) begin
        st.pcSel = taken ? PC_IMM : PC_INC2;
      end else if (opcode[15:4] == OP_CABS) begin
        st.pcSel   = taken ? PC_IMM : PC_INC2;
        st.push    = taken;
        st.pushTwo = 1'b1;
      end else if (opcode[15:4] == OP_RET) begin
        st.pcSel = taken ? PC_POP : PC_INC1;
        st.pop   = taken;
      end else if (opcode[15:4] == OP_SKIP) begin
        st.pcSel = taken ? PC_INC1 : PC_SKIP;
      end else if (opcode[15:8] == OP_RIND) begin
        st.pcSel = taken ? PC_REG : PC_INC1;
        st.push  = taken && opcode[4];
      end
    end
  end

endmodule

// File: rtl/branch_seq_dp.sv
module branch_seq_dp
  import branch_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    st,
  input  logic [AW-1:0]              nextWord,
  input  logic [AW-1:0]              regData,
  input  logic [1:0]                 nextLen,
  input  logic                       haltClr,
  output logic [AW-1:0]              pc,
  output logic                       halted,
  output logic                       stackErr,
  output logic [$clog2(DEPTH+1)-1:0] stkCnt
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] stkMem [DEPTH];
  logic [AW-1:0] pcNext;
  logic [AW-1:0] retAddr;
  logic [AW-1:0] popVal;
  logic [CW-1:0] cntDec;
  logic          stkFull;
  logic          stkEmpty;

  assign stkFull  = (stkCnt == FULL_CNT);
  assign stkEmpty = (stkCnt == '0);
  assign cntDec   = stkCnt - 1'b1;
  assign popVal   = stkMem[cntDec[IW-1:0]];
  assign retAddr  = st.pushTwo ? pc + AW'(2) : pc + AW'(1);

  always_comb begin
    unique case (st.pcSel)
      PC_INC1: pcNext = pc + AW'(1);
      PC_INC2: pcNext = pc + AW'(2);
      PC_IMM:  pcNext = nextWord;
      PC_REG:  pcNext = regData;
      PC_POP:  pcNext = stkEmpty ? pc + AW'(1) : popVal;
      PC_SKIP: pcNext = pc + AW'(1) + {{(AW-2){1'b0}}, nextLen};
      default: pcNext = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= '0;
      halted   <= 1'b0;
      stackErr <= 1'b0;
      stkCnt   <= '0;
    end else begin
      pc <= pcNext;
      if (st.setHalt)   halted <= 1'b1;
      else if (haltClr) halted <= 1'b0;
      if (st.push) begin
        if (stkFull) stackErr <= 1'b1;
        else         stkCnt   <= stkCnt + 1'b1;
      end else if (st.pop) begin
        if (stkEmpty) stackErr <= 1'b1;
        else          stkCnt   <= cntDec;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.push && !stkFull) stkMem[stkCnt[IW-1:0]] <= retAddr;
  end

endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import branch_seq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        valid,
  input  logic [15:0] opcode,
  input  logic [15:0] nextWord,
  input  logic [15:0] regData,
  input  logic        condMet,
  input  logic [1:0]  nextLen,
  input  logic [15:0] dsTop,
  input  logic        haltClr,
  output logic [2:0]  regSel,
  output logic [15:0] pc,
  output logic        srWrEn,
  output logic [15:0] srWrData,
  output logic        dsPop,
  output logic        halted,
  output logic        stackErr
);

  localparam int AW = 16;
  localparam int CW = $clog2(DEPTH + 1);

  strobe_t       st;
  logic          exec;
  logic [CW-1:0] stkCnt;

  assign exec     = valid && !halted;
  assign srWrData = dsTop;

  branch_seq_ctrl uCtrl (
    .exec    (exec),
    .opcode  (opcode),
    .condMet (condMet),
    .st      (st),
    .regSel  (regSel),
    .srWrEn  (srWrEn),
    .dsPop   (dsPop)
  );

  branch_seq_dp #(.AW(AW), .DEPTH(DEPTH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .nextWord (nextWord),
    .regData  (regData),
    .nextLen  (nextLen),
    .haltClr  (haltClr),
    .pc       (pc),
    .halted   (halted),
    .stackErr (stackErr),
    .stkCnt   (stkCnt)
  );

endmodule

// File: rtl/branch_seq_check.sv
module branch_seq_check #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       valid,
  input logic [15:0]                opcode,
  input logic [15:0]                nextWord,
  input logic                       condMet,
  input logic                       haltClr,
  input logic [15:0]                pc,
  input logic                       halted,
  input logic                       stackErr,
  input logic [$clog2(DEPTH+1)-1:0] stkCnt
);

  logic run;
  logic jTaken;
  assign run    = valid && !halted;
  assign jTaken = run && (opcode[15:4] == 12'h029) && (condMet || (opcode[3:0] == 4'hF));

  // R2 / R3: a taken absolute jump lands on the target word
  a_r2_jump_taken: assert property (@(posedge clk) disable iff (!rstN)
    jTaken |=> (pc == $past(nextWord)));

  // R2: a jump not taken steps over both words
  a_r2_jump_fall: assert property (@(posedge clk) disable iff (!rstN)
    (run && (opcode[15:4] == 12'h029) && !condMet && (opcode[3:0] != 4'hF))
      |=> (pc == $past(pc) + 16'd2));

  // R9: halt instruction raises the flag
  a_r9_halt_set: assert property (@(posedge clk) disable iff (!rstN)
    (run && (opcode == 16'h0021)) |=> halted);

  // R9: a halted core keeps its PC until cleared
  a_r9_halt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !haltClr) |=> ($stable(pc) && halted));

  // R11: error flag never drops without reset
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);

  // R10: depth never exceeds capacity
  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    stkCnt <= ($clog2(DEPTH+1))'(DEPTH));

endmodule

bind branch_seq branch_seq_check #(.DEPTH(DEPTH)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .valid    (valid),
  .opcode   (opcode),
  .nextWord (nextWord),
  .condMet  (condMet),
  .haltClr  (haltClr),
  .pc       (pc),
  .halted   (halted),
  .stackErr (stackErr),
  .stkCnt   (stkCnt)
);

// File: tb/branch_seq_test.sv
`timescale 1ns/1ps
module branch_seq_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        valid;
  logic [15:0] opcode;
  logic [15:0] nextWord;
  logic [15:0] regData;
  logic        condMet;
  logic [1:0]  nextLen;
  logic [15:0] dsTop;
  logic        haltClr;
  logic [2:0]  regSel;
  logic [15:0] pc;
  logic        srWrEn;
  logic [15:0] srWrData;
  logic        dsPop;
  logic        halted;
  logic        stackErr;

  int nRun  = 0;
  int nFail = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  branch_seq uut (
    .clk(clk), .rstN(rstN), .valid(valid), .opcode(opcode), .nextWord(nextWord),
    .regData(regData), .condMet(condMet), .nextLen(nextLen), .dsTop(dsTop),
    .haltClr(haltClr), .regSel(regSel), .pc(pc), .srWrEn(srWrEn),
    .srWrData(srWrData), .dsPop(dsPop), .halted(halted), .stackErr(stackErr)
  );

  // {valid, opcode, nextWord, regData, condMet, nextLen, expected pc}
  localparam logic [67:0] VEC [16] = '{
    {1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b0, 2'd1, 16'h0001},
    {1'b1, 16'h0290, 16'h0100, 16'h0000, 1'b1, 2'd1, 16'h0100},
    {1'b1, 16'h0291, 16'h0500, 16'h0000, 1'b0, 2'd1, 16'h0102},
    {1'b1, 16'h029F, 16'h0200, 16'h0000, 1'b0, 2'd1, 16'h0200},
    {1'b1, 16'h02B3, 16'h0300, 16'h0000, 1'b0, 2'd1, 16'h0202},
    {1'b1, 16'h02B3, 16'h0300, 16'h0000, 1'b1, 2'd1, 16'h0300},
    {1'b1, 16'h0275, 16'h0000, 16'h0000, 1'b0, 2'd2, 16'h0303},
    {1'b1, 16'h0275, 16'h0000, 16'h0000, 1'b1, 2'd2, 16'h0304},
    {1'b1, 16'h0275, 16'h0000, 16'h0000, 1'b0, 2'd1, 16'h0306},
    {1'b1, 16'h1742, 16'h0000, 16'h0400, 1'b1, 2'd1, 16'h0400},
    {1'b1, 16'h17B4, 16'h0000, 16'h0500, 1'b1, 2'd1, 16'h0500},
    {1'b1, 16'h1761, 16'h0000, 16'h0000, 1'b0, 2'd1, 16'h0501},
    {1'b1, 16'h02D0, 16'h0000, 16'h0000, 1'b0, 2'd1, 16'h0502},
    {1'b1, 16'h02D0, 16'h0000, 16'h0000, 1'b1, 2'd1, 16'h0401},
    {1'b1, 16'h02DF, 16'h0000, 16'h0000, 1'b0, 2'd1, 16'h0204},
    {1'b0, 16'h0290, 16'h0900, 16'h0000, 1'b1, 2'd1, 16'h0204}
  };

  function automatic string reqOf(logic v, logic [15:0] op, logic c);
    if (!v) return "R12";
    if (op[3:0] == 4'hF && !c) return "R3";
    case (op[15:4])
      12'h029: return "R2";
      12'h02B: return "R4";
      12'h02D: return "R6";
      12'h027: return "R8";
      default: ;
    endcase
    if (op[15:8] == 8'h17) return "R5";
    return "R12";
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    valid = 0; opcode = 16'h0000; nextWord = 0; regData = 0;
    condMet = 0; nextLen = 2'd1; dsTop = 0; haltClr = 0;
  endtask

  task automatic doReset();
    idle();
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;
  endtask

  task automatic exec1(logic [15:0] op, logic [15:0] nw, logic c);
    valid = 1; opcode = op; nextWord = nw; condMet = c;
    @(posedge clk); #1;
    idle();
  endtask

  logic [15:0] saved [8];
  logic [15:0] p0;

  initial begin
    doReset();
    check("R1", pc, 16'h0000);
    check("R1", {15'd0, halted}, 16'h0);
    check("R1", {15'd0, stackErr}, 16'h0);

    for (int i = 0; i < 16; i++) begin
      valid = VEC[i][67]; opcode = VEC[i][66:51]; nextWord = VEC[i][50:35];
      regData = VEC[i][34:19]; condMet = VEC[i][18]; nextLen = VEC[i][17:16];
      @(posedge clk); #1;
      check(reqOf(VEC[i][67], VEC[i][66:51], VEC[i][18]), pc, VEC[i][15:0]);
      idle();
    end
    check("R10", {15'd0, stackErr}, 16'h0);

    // R5: register select field
    opcode = 16'h17B4; #1;
    check("R5", {13'd0, regSel}, 16'h0005);
    idle();

    // R6: return on an empty stack with condition false does not pop or err
    p0 = pc;
    exec1(16'h02D2, 16'h0, 1'b0);
    check("R6", pc, p0 + 16'd1);
    check("R6", {15'd0, stackErr}, 16'h0);

    // R7: return from interrupt
    p0 = pc;
    exec1(16'h02BF, 16'h0700, 1'b0);
    valid = 1; opcode = 16'h02FF; dsTop = 16'hBEEF; #1;
    check("R7", {15'd0, srWrEn}, 16'h1);
    check("R7", {15'd0, dsPop}, 16'h1);
    check("R7", srWrData, 16'hBEEF);
    @(posedge clk); #1;
    idle(); #1;
    check("R7", pc, p0 + 16'd2);
    check("R7", {15'd0, srWrEn}, 16'h0);

    // R10: overflow and LIFO order
    doReset();
    for (int i = 0; i < 9; i++) begin
      p0 = pc;
      if (i < 8) saved[i] = p0 + 16'd2;
      exec1(16'h02BF, 16'h1000 + 16'(i * 16), 1'b0);
      check("R10", pc, 16'h1000 + 16'(i * 16));
      if (i == 7) check("R10", {15'd0, stackErr}, 16'h0);
    end
    check("R10", {15'd0, stackErr}, 16'h1);
    for (int i = 7; i >= 0; i--) begin
      exec1(16'h02DF, 16'h0, 1'b0);
      check("R10", pc, saved[i]);
    end
    p0 = pc;
    exec1(16'h02DF, 16'h0, 1'b0);
    check("R10", pc, p0 + 16'd1);
    exec1(16'h0000, 16'h0, 1'b0);
    check("R11", {15'd0, stackErr}, 16'h1);

    // R9: halt, hold, clear, collision with clear
    doReset();
    exec1(16'h0000, 16'h0, 1'b0);
    p0 = pc;
    exec1(16'h0021, 16'h0, 1'b0);
    check("R9", {15'd0, halted}, 16'h1);
    check("R9", pc, p0 + 16'd1);
    exec1(16'h029F, 16'h0800, 1'b1);
    check("R9", pc, p0 + 16'd1);
    haltClr = 1;
    @(posedge clk); #1;
    idle();
    check("R9", {15'd0, halted}, 16'h0);
    check("R9", pc, p0 + 16'd1);
    valid = 1; opcode = 16'h0021; haltClr = 1;
    @(posedge clk); #1;
    idle();
    check("R9", {15'd0, halted}, 16'h1);
    exec1(16'h029F, 16'h0800, 1'b1);
    check("R9", pc, p0 + 16'd2);

    if (!doneFlag) begin
      doneFlag = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      nRun++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule